// File: doc/BRIEF.md
# Manchester Bus Word Decoder

This block turns one oversampled differential line pair into received bus words. Each word lasts 20 bit-times on the line. It opens with a sync waveform of 3 bit-times, then carries 16 data bits and closes with one parity bit. The sync waveform alone decides whether the word is a command/status word or a data word. The data bits never take part in that decision.

A word is accepted only when four things hold: the sync is well formed, every bit has its mid-bit transition, exactly 17 bits follow the sync, and parity is odd. An accepted word is presented as its 16 data bits with a type flag and a one-clock valid strobe. The sync and parity are not part of the output. A rejected word produces one-clock error flags instead.

Each clock is one line sample, and `SAMPLES_PER_BIT` samples make one bit-time. Interpreting a command's address, direction, subaddress and count fields, which sit from the MSB downward, is left to the logic downstream. Response timing is also left downstream.

The controller is a state machine with six named states:

- IDLE waits for the line to leave idle.
- SYNC_A holds the first sync half.
- SYNC_B holds the second sync half.
- DATA handles each of the 17 bits.
- TAIL checks half a bit-time after parity.
- WAIT_IDLE waits for a quiet line after an error.

The transitions are:

- IDLE to SYNC_A on the first active sample.
- SYNC_A to SYNC_B after 1.5 bit-times.
- SYNC_B to DATA after 1.5 bit-times.
- DATA to TAIL after bit 17.
- TAIL to IDLE on a completed word.
- SYNC_A, SYNC_B, DATA or TAIL to WAIT_IDLE on a fault.
- WAIT_IDLE to IDLE after one idle bit-time.

Top module: `mbd_decoder`

## Requirements
- R1: The pair encodes the line as follows: (pos=1, neg=0) is a one, (pos=0, neg=1) is a zero, and equal levels are idle. Any length of idle, including both lines high, produces no output pulse.
- R2: A command sync is 1.5 bit-times of one followed by 1.5 bit-times of zero, and it gives `word_is_cmd`=1. A data sync is the inverse and gives `word_is_cmd`=0, whatever the data bits hold.
- R3: If any sample in the sync window breaks the expected waveform or is idle, `err_sync` pulses. The decoder then ignores the line until it has seen one bit-time of idle, so the rest of that word produces no further pulse.
- R4: Data bits arrive MSB first, and the first bit after sync lands in `word_data[15]`. The parity bit follows bit 0 and is removed. `word_data` and `word_is_cmd` change only together with `word_valid`.
- R5: Each bit is sampled at the middle of both halves. A one is sent one-then-zero and a zero is sent zero-then-one. If the two halves are equal, `err_manch` is raised at the end of the word.
- R6: Parity over the 16 data bits plus the parity bit must be odd; otherwise `err_parity` is raised at the end of the word.
- R7: An idle line at a sample point before the 17th bit is complete raises `err_count`. So does an active line half a bit-time after the parity bit, which indicates an extra bit.
- R8: `word_valid` and all error flags are single-clock pulses. `word_valid` never coincides with an error flag. Each word yields exactly one pulse event.
- R9: After reset all outputs are zero.
- R10: Words separated by at least one bit-time of idle are each decoded independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one line sample per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| line_pos | input | 1 | Positive side of the line pair |
| line_neg | input | 1 | Negative side of the line pair |
| word_data | output | 16 | Data bits of the last valid word |
| word_is_cmd | output | 1 | 1 = command sync, 0 = data sync, for the last valid word |
| word_valid | output | 1 | One-clock strobe for an accepted word |
| err_sync | output | 1 | One-clock flag: malformed sync |
| err_manch | output | 1 | One-clock flag: a bit without mid-bit transition |
| err_count | output | 1 | One-clock flag: too few or too many bits |
| err_parity | output | 1 | One-clock flag: even parity |

## Verification
The main stimulus is a stream of random words with random type and data. Some have correct parity, some have the parity bit flipped, and some have one bit with equal halves. These patterns separate a correct parity computation from an inverted one, and a true mid-bit check from one that only reads the first half.

Directed words pair a data sync with all-ones data and a command sync with all-zeros data, which shows that the type comes from the waveform and not from the data. Truncated and over-long words separate the two bit-count faults from parity and coding faults. A stretched sync and a long stretch with both lines high separate sync rejection from idle handling. After each rejected word, the bench confirms that the held output still shows the previous good word.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC_A,
        ST_SYNC_B,
        ST_DATA,
        ST_TAIL,
        ST_WAIT_IDLE
    } mbd_state_e;

    localparam int unsigned WORD_BITS  = 16;
    localparam int unsigned FRAME_BITS = WORD_BITS + 1;

endpackage

// File: rtl/mbd_line_sampler.sv
module mbd_line_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic line_pos,
    input  logic line_neg,
    output logic smp_active,
    output logic smp_level
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_active <= 1'b0;
            smp_level  <= 1'b0;
        end else begin
            smp_active <= line_pos ^ line_neg;
            smp_level  <= line_pos;
        end
    end

endmodule

// File: rtl/mbd_word_fsm.sv
module mbd_word_fsm
    import mbd_pkg::*;
#(
    parameter int unsigned SAMPLES_PER_BIT = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_active,
    input  logic                 smp_level,
    output logic                 ev_good,
    output logic                 ev_sync,
    output logic                 ev_manch,
    output logic                 ev_count,
    output logic                 ev_parity,
    output logic                 ev_cmd,
    output logic [WORD_BITS-1:0] ev_data
);

    localparam int unsigned HALF     = SAMPLES_PER_BIT / 2;
    localparam int unsigned QUART    = HALF / 2;
    localparam int unsigned SYNC_LEN = 3 * HALF;
    localparam int unsigned CW       = $clog2(SYNC_LEN + 1);
    localparam logic [CW-1:0] C_Q1   = CW'(QUART);
    localparam logic [CW-1:0] C_Q2   = CW'(HALF + QUART);
    localparam logic [CW-1:0] C_BIT  = CW'(SAMPLES_PER_BIT - 1);
    localparam logic [CW-1:0] C_SYNC = CW'(SYNC_LEN - 1);
    localparam logic [4:0]    C_NB   = 5'(FRAME_BITS);

    mbd_state_e            st_q, st_n;
    logic [CW-1:0]         cnt_q, cnt_n;
    logic [4:0]            bitn_q, bitn_n;
    logic                  polar_q, polar_n;
    logic                  h1_q, h1_n;
    logic                  manch_q, manch_n;
    logic [FRAME_BITS-1:0] sreg_q, sreg_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            bitn_q  <= '0;
            polar_q <= 1'b0;
            h1_q    <= 1'b0;
            manch_q <= 1'b0;
            sreg_q  <= '0;
        end else begin
            st_q    <= st_n;
            cnt_q   <= cnt_n;
            bitn_q  <= bitn_n;
            polar_q <= polar_n;
            h1_q    <= h1_n;
            manch_q <= manch_n;
            sreg_q  <= sreg_n;
        end
    end

    assign ev_data = sreg_q[FRAME_BITS-1:1];
    assign ev_cmd  = polar_q;

    always_comb begin
        st_n      = st_q;
        cnt_n     = cnt_q;
        bitn_n    = bitn_q;
        polar_n   = polar_q;
        h1_n      = h1_q;
        manch_n   = manch_q;
        sreg_n    = sreg_q;
        ev_good   = 1'b0;
        ev_sync   = 1'b0;
        ev_manch  = 1'b0;
        ev_count  = 1'b0;
        ev_parity = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (smp_active) begin
                    polar_n = smp_level;
                    cnt_n   = CW'(1);
                    st_n    = ST_SYNC_A;
                end
            end
            ST_SYNC_A: begin
                if (!smp_active || smp_level != polar_q) begin
                    ev_sync = 1'b1;
                    cnt_n   = '0;
                    st_n    = ST_WAIT_IDLE;
                end else if (cnt_q == C_SYNC) begin
                    cnt_n = '0;
                    st_n  = ST_SYNC_B;
                end else begin
                    cnt_n = cnt_q + CW'(1);
                end
            end
            ST_SYNC_B: begin
                if (!smp_active || smp_level == polar_q) begin
                    ev_sync = 1'b1;
                    cnt_n   = '0;
                    st_n    = ST_WAIT_IDLE;
                end else if (cnt_q == C_SYNC) begin
                    cnt_n   = '0;
                    bitn_n  = '0;
                    manch_n = 1'b0;
                    st_n    = ST_DATA;
                end else begin
                    cnt_n = cnt_q + CW'(1);
                end
            end
            ST_DATA: begin
                cnt_n = cnt_q + CW'(1);
                if ((cnt_q == C_Q1 || cnt_q == C_Q2) && !smp_active) begin
                    ev_count = 1'b1;
                    cnt_n    = '0;
                    st_n     = ST_WAIT_IDLE;
                end else if (cnt_q == C_Q1) begin
                    h1_n = smp_level;
                end else if (cnt_q == C_Q2) begin
                    if (smp_level == h1_q) manch_n = 1'b1;
                    sreg_n = {sreg_q[FRAME_BITS-2:0], h1_q};
                    bitn_n = bitn_q + 5'd1;
                end else if (cnt_q == C_BIT) begin
                    cnt_n = '0;
                    if (bitn_q == C_NB) st_n = ST_TAIL;
                end
            end
            ST_TAIL: begin
                cnt_n = cnt_q + CW'(1);
                if (cnt_q == C_Q1) begin
                    cnt_n = '0;
                    if (smp_active) begin
                        ev_count = 1'b1;
                        st_n     = ST_WAIT_IDLE;
                    end else begin
                        ev_manch  = manch_q;
                        ev_parity = ~(^sreg_q);
                        ev_good   = ~manch_q & (^sreg_q);
                        st_n      = ST_IDLE;
                    end
                end
            end
            ST_WAIT_IDLE: begin
                if (smp_active) begin
                    cnt_n = '0;
                end else if (cnt_q == C_BIT) begin
                    cnt_n = '0;
                    st_n  = ST_IDLE;
                end else begin
                    cnt_n = cnt_q + CW'(1);
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // R7
    tail_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TAIL) |-> (bitn_q == C_NB));

    // R3
    sync_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_sync |=> (st_q == ST_WAIT_IDLE));

    // R2
    sync_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SYNC_A) |=> (st_q inside {ST_SYNC_A, ST_SYNC_B, ST_WAIT_IDLE}));

endmodule

// File: rtl/mbd_result_reg.sv
module mbd_result_reg
    import mbd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ev_good,
    input  logic                 ev_sync,
    input  logic                 ev_manch,
    input  logic                 ev_count,
    input  logic                 ev_parity,
    input  logic                 ev_cmd,
    input  logic [WORD_BITS-1:0] ev_data,
    output logic [WORD_BITS-1:0] word_data,
    output logic                 word_is_cmd,
    output logic                 word_valid,
    output logic                 err_sync,
    output logic                 err_manch,
    output logic                 err_count,
    output logic                 err_parity
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_data   <= '0;
            word_is_cmd <= 1'b0;
            word_valid  <= 1'b0;
            err_sync    <= 1'b0;
            err_manch   <= 1'b0;
            err_count   <= 1'b0;
            err_parity  <= 1'b0;
        end else begin
            word_valid <= ev_good;
            err_sync   <= ev_sync;
            err_manch  <= ev_manch;
            err_count  <= ev_count;
            err_parity <= ev_parity;
            if (ev_good) begin
                word_data   <= ev_data;
                word_is_cmd <= ev_cmd;
            end
        end
    end

    // R8
    valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> !(err_sync | err_manch | err_count | err_parity));

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R3
    sync_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_sync |=> !err_sync);

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> ($stable(word_data) && $stable(word_is_cmd)));

endmodule

// File: rtl/mbd_decoder.sv
module mbd_decoder
    import mbd_pkg::*;
#(
    parameter int unsigned SAMPLES_PER_BIT = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        line_pos,
    input  logic        line_neg,
    output logic [15:0] word_data,
    output logic        word_is_cmd,
    output logic        word_valid,
    output logic        err_sync,
    output logic        err_manch,
    output logic        err_count,
    output logic        err_parity
);

    logic                 smp_active, smp_level;
    logic                 ev_good, ev_sync, ev_manch, ev_count, ev_parity, ev_cmd;
    logic [WORD_BITS-1:0] ev_data;

    mbd_line_sampler u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_pos   (line_pos),
        .line_neg   (line_neg),
        .smp_active (smp_active),
        .smp_level  (smp_level)
    );

    mbd_word_fsm #(.SAMPLES_PER_BIT(SAMPLES_PER_BIT)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_active (smp_active),
        .smp_level  (smp_level),
        .ev_good    (ev_good),
        .ev_sync    (ev_sync),
        .ev_manch   (ev_manch),
        .ev_count   (ev_count),
        .ev_parity  (ev_parity),
        .ev_cmd     (ev_cmd),
        .ev_data    (ev_data)
    );

    mbd_result_reg u_result (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_good     (ev_good),
        .ev_sync     (ev_sync),
        .ev_manch    (ev_manch),
        .ev_count    (ev_count),
        .ev_parity   (ev_parity),
        .ev_cmd      (ev_cmd),
        .ev_data     (ev_data),
        .word_data   (word_data),
        .word_is_cmd (word_is_cmd),
        .word_valid  (word_valid),
        .err_sync    (err_sync),
        .err_manch   (err_manch),
        .err_count   (err_count),
        .err_parity  (err_parity)
    );

endmodule

// File: tb/mbd_decoder_tb.sv
`timescale 1ns/1ps
module mbd_decoder_tb_top;

    localparam int SPB  = 8;
    localparam int HALF = SPB / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_pos = 1'b0;
    logic        line_neg = 1'b0;
    logic [15:0] word_data;
    logic        word_is_cmd, word_valid, err_sync, err_manch, err_count, err_parity;

    int n_cmp = 0;
    int n_bad = 0;
    int ev_n = 0;
    logic [4:0]  ev_flags;
    logic [15:0] last_data = 16'h0;
    logic        last_cmd = 1'b0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    mbd_decoder #(.SAMPLES_PER_BIT(SPB)) dut_i (
        .clk(clk), .rst_n(rst_n), .line_pos(line_pos), .line_neg(line_neg),
        .word_data(word_data), .word_is_cmd(word_is_cmd), .word_valid(word_valid),
        .err_sync(err_sync), .err_manch(err_manch), .err_count(err_count),
        .err_parity(err_parity)
    );

    // flag vector order: {valid, sync, manch, count, parity}
    always @(negedge clk) begin
        if (rst_n && (word_valid | err_sync | err_manch | err_count | err_parity)) begin
            ev_n++;
            ev_flags = {word_valid, err_sync, err_manch, err_count, err_parity};
        end
    end

    function automatic logic odd_par(input logic [15:0] d);
        return ~(^d);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic lvl, input logic idle, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            line_pos = idle ? 1'b0 : lvl;
            line_neg = idle ? 1'b0 : ~lvl;
        end
    endtask

    // nbits: number of frame bits sent; extra bits are ones
    task automatic send_word(input logic is_cmd, input logic [15:0] d, input bit flip_par,
                             input int bad_bit, input int nbits, input bit bad_sync);
        logic [16:0] fr;
        logic        b;
        fr = {d, odd_par(d) ^ flip_par};
        drive(is_cmd, 1'b0, 3 * HALF);
        drive(bad_sync ? is_cmd : ~is_cmd, 1'b0, 3 * HALF);
        for (int i = 0; i < nbits; i++) begin
            b = (i < 17) ? fr[16 - i] : 1'b1;
            drive(b, 1'b0, HALF);
            drive((i == bad_bit) ? b : ~b, 1'b0, HALF);
        end
        drive(1'b0, 1'b1, 3 * SPB);
    endtask

    task automatic expect_ev(input string req, input logic [4:0] exp_flags,
                             input logic exp_cmd, input logic [15:0] exp_data);
        check(ev_n == 1, req, "event count", ev_n, 1);
        check(ev_flags == exp_flags, req, "flags", ev_flags, exp_flags);
        if (exp_flags[4]) begin
            last_data = exp_data;
            last_cmd  = exp_cmd;
        end
        check(word_data == last_data, "R4", "held data", word_data, last_data);
        check(word_is_cmd == last_cmd, "R2", "held type", word_is_cmd, last_cmd);
        ev_n = 0;
        ev_flags = '0;
    endtask

    initial begin
        int kind;
        logic c;
        logic [15:0] d;
        int bb;
        void'($urandom(32'h1553_0a5e));
        repeat (5) @(negedge clk);
        // R9 reset state
        check({word_valid, err_sync, err_manch, err_count, err_parity, word_is_cmd} == 6'b0
              && word_data == 16'h0, "R9", "reset outputs", word_data, 0);
        rst_n = 1'b1;
        drive(1'b0, 1'b1, 2 * SPB);

        // R2 type from sync, not data; R4 MSB first
        send_word(1'b0, 16'hFFFF, 0, -1, 17, 0);
        expect_ev("R2", 5'b10000, 1'b0, 16'hFFFF);
        send_word(1'b1, 16'h0000, 0, -1, 17, 0);
        expect_ev("R2", 5'b10000, 1'b1, 16'h0000);
        send_word(1'b1, 16'h8001, 0, -1, 17, 0);
        expect_ev("R4", 5'b10000, 1'b1, 16'h8001);

        // R1 both lines high is idle
        @(negedge clk); line_pos = 1'b1; line_neg = 1'b1;
        repeat (6 * SPB) @(negedge clk);
        line_pos = 1'b0; line_neg = 1'b0;
        repeat (2 * SPB) @(negedge clk);
        check(ev_n == 0, "R1", "pulses during idle", ev_n, 0);

        // R3 malformed sync
        send_word(1'b1, 16'h1234, 0, -1, 17, 1);
        expect_ev("R3", 5'b01000, 1'b0, 16'h0);
        // R5 missing mid-bit transition
        send_word(1'b0, 16'hA5A5, 0, 0, 17, 0);
        expect_ev("R5", 5'b00100, 1'b0, 16'h0);
        send_word(1'b0, 16'hA5A5, 0, 16, 17, 0);
        expect_ev("R5", 5'b00100, 1'b0, 16'h0);
        // R6 parity
        send_word(1'b1, 16'h0F0F, 1, -1, 17, 0);
        expect_ev("R6", 5'b00001, 1'b0, 16'h0);
        // R7 truncated and extended
        send_word(1'b0, 16'h3C3C, 0, -1, 16, 0);
        expect_ev("R7", 5'b00010, 1'b0, 16'h0);
        send_word(1'b0, 16'h3C3C, 0, -1, 18, 0);
        expect_ev("R7", 5'b00010, 1'b0, 16'h0);
        // R10 recovery after errors
        send_word(1'b1, 16'h5A5A, 0, -1, 17, 0);
        expect_ev("R10", 5'b10000, 1'b1, 16'h5A5A);

        // R8 random mix
        for (int w = 0; w < 40; w++) begin
            kind = int'($urandom % 4);
            c    = 1'($urandom);
            d    = 16'($urandom);
            bb   = int'($urandom % 17);
            if (kind < 2) begin
                send_word(c, d, 0, -1, 17, 0);
                expect_ev("R8", 5'b10000, c, d);
            end else if (kind == 2) begin
                send_word(c, d, 1, -1, 17, 0);
                expect_ev("R6", 5'b00001, c, d);
            end else begin
                send_word(c, d, 0, bb, 17, 0);
                expect_ev("R5", 5'b00100, c, d);
            end
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule